// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Per-Character Error Status

This block takes an asynchronous serial line carrying 8-bit characters and turns it into a queue of received characters, each tagged with its own error bits. A one-cycle `tick16` strobe, sixteen per bit time, paces all sampling. The line first crosses a two-flop synchronizer. A state machine then confirms the start bit, shifts in eight data bits least significant first, and checks an optional parity bit and the stop bit. It also recognises a line held low for longer than a whole frame as a break. Every finished character goes into a small receive queue together with its break, parity and framing flags.

The status outputs always describe the character at the head of the queue. A sticky overrun flag records that a character arrived while the queue was full. A one-cycle pulse on `clr_wr` stands for a write of any value to the error-clear register. It clears all four flags at once. The flags themselves cannot be written. The clear register has no read path.

The state machine has seven states. IDLE goes to START on a low sample at a tick. START goes to DATA if the line is still low at the eighth tick, and otherwise back to IDLE. DATA goes to PARITY after the eighth data sample when parity is enabled, and otherwise to STOP. PARITY goes to STOP after its sample. STOP goes to IDLE when the stop bit is high, or when it is low but some earlier bit was high. STOP goes to BRKCHK when every sample so far, stop included, was low. BRKCHK goes to IDLE if the line is high one bit time later, and otherwise to BRKWAIT. BRKWAIT goes to IDLE only once the line reads high.

Top module: `async_rx_core`

## Requirements
- R1: A low level seen at a tick starts a frame only if the line is still low at the eighth tick after it; otherwise the receiver returns to idle and stores nothing.
- R2: Data bits are taken least significant first, each sampled sixteen ticks after the previous sample. A frame whose stop sample is 1 stores its data with the framing flag 0.
- R3: With `par_en`=1 and `par_stick`=0, the expected parity bit is the XOR of the data bits when `par_even`=1, and its inverse when `par_even`=0. A mismatch sets the parity flag of that character. With `par_en`=0 no parity bit is expected and the parity flag is 0.
- R4: With `par_en`=1 and `par_stick`=1, the expected parity bit is the constant 0 when `par_even`=1 and the constant 1 when `par_even`=0.
- R5: A stop sample of 0 sets the framing flag of the stored character. A frame whose data, parity and stop samples are all 0 is stored with data 0x00 and the framing flag set when the line is high one bit time after the stop sample.
- R6: When the line is still low one bit time after an all-zero frame's stop sample, exactly one character is stored. It has data 0x00, break flag 1, parity flag 0 and framing flag 0.
- R7: After a break, nothing more is stored while the line stays low. Reception resumes only after the line returns high and a new valid start bit arrives.
- R8: Characters leave the queue in arrival order. `head_valid` is 1 while the queue holds a character, and `head_data` shows the oldest one. `rd_pop` removes it, and a pop on an empty queue has no effect.
- R9: `stat_brk`, `stat_par` and `stat_frm` show the flags of the character at the queue head, and are 0 while the queue is empty.
- R10: A character that completes while the queue holds `DEPTH` (default 4) entries is discarded. The queue contents are kept and `stat_ovr` goes to 1 and stays there until cleared. Setting wins over a clear in the same cycle.
- R11: A `clr_wr` pulse clears all four status outputs from the next cycle. The three character flags stay hidden until the head changes, by a pop or by a push into an empty queue. A clear in the same cycle as such a change still hides the new head's flags.
- R12: After reset the queue is empty and all status outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Oversampling strobe, 16 per bit time |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even parity select (or stick value select) |
| par_stick | input | 1 | Stick parity select |
| rd_pop | input | 1 | Remove the head character |
| clr_wr | input | 1 | Write strobe of the error-clear register |
| head_valid | output | 1 | Queue not empty |
| head_data | output | 8 | Data of the head character |
| stat_brk | output | 1 | Break flag of the head character |
| stat_par | output | 1 | Parity flag of the head character |
| stat_frm | output | 1 | Framing flag of the head character |
| stat_ovr | output | 1 | Sticky overrun flag |

## Verification
A wrong sampling phase or bit counter inside the receiver shows up as a wrong `head_data` or a spurious framing flag. It appears on the first cycle after the character's stop sample, when the queue head changes. A state machine stuck outside BRKWAIT after a break shows as an extra stored character within about one frame time of continued low line. A stale clear mask or overrun bit is visible on the next cycle, either in the flags of the new head after a pop or in `stat_ovr` after the queue fills. The bench compares every output against its model on each clock while the line is settled, so any of these shows up at the latest one frame after the fault.

// File: rtl/arx_pkg.sv
package arx_pkg;

    localparam int DATA_W = 8;

    typedef struct packed {
        logic              brk;
        logic              par;
        logic              frm;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PARITY,
        S_STOP,
        S_BRKCHK,
        S_BRKWAIT
    } rx_state_t;

    // Parity bit the sender should have produced for this data and configuration.
    function automatic logic want_parity(logic [DATA_W-1:0] d, logic even, logic stick);
        if (stick)
            return ~even;
        return even ? (^d) : ~(^d);
    endfunction

endpackage

// File: rtl/arx_sync.sv
module arx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ff <= '1;
        else
            ff <= {ff[STAGES-2:0], d};
    end

    assign q = ff[STAGES-1];
endmodule

// File: rtl/arx_frame.sv
module arx_frame
    import arx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      rx,
    input  logic      par_en,
    input  logic      par_even,
    input  logic      par_stick,
    output logic      push,
    output rx_entry_t entry,
    output rx_state_t state_o
);
    localparam int CW = $clog2(OSR);
    localparam int BW = $clog2(DATA_W);
    localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);
    localparam logic [BW-1:0] BLAST = BW'(DATA_W - 1);

    rx_state_t         state, nxt;
    logic [CW-1:0]     tcnt, tnext;
    logic [BW-1:0]     bidx;
    logic [DATA_W-1:0] shreg;
    logic              all_low;
    logic              par_err;
    logic              at_mid, at_last;

    assign at_mid  = (tcnt == MID);
    assign at_last = (tcnt == LAST);
    assign tnext   = at_last ? '0 : tcnt + 1'b1;
    assign state_o = state;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (tick && !rx) nxt = S_START;
            S_START:   if (tick && at_mid) nxt = rx ? S_IDLE : S_DATA;
            S_DATA:    if (tick && at_last && bidx == BLAST) nxt = par_en ? S_PARITY : S_STOP;
            S_PARITY:  if (tick && at_last) nxt = S_STOP;
            S_STOP:    if (tick && at_last) nxt = (!rx && all_low) ? S_BRKCHK : S_IDLE;
            S_BRKCHK:  if (tick && at_last) nxt = rx ? S_IDLE : S_BRKWAIT;
            S_BRKWAIT: if (rx) nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt    <= '0;
            bidx    <= '0;
            shreg   <= '0;
            all_low <= 1'b0;
            par_err <= 1'b0;
            push    <= 1'b0;
            entry   <= '0;
        end else begin
            push <= 1'b0;
            if (tick) begin
                unique case (state)
                    S_IDLE, S_BRKWAIT: tcnt <= '0;
                    S_START: begin
                        if (at_mid) begin
                            tcnt    <= '0;
                            bidx    <= '0;
                            all_low <= 1'b1;
                            par_err <= 1'b0;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    S_DATA: begin
                        tcnt <= tnext;
                        if (at_last) begin
                            shreg   <= {rx, shreg[DATA_W-1:1]};
                            all_low <= all_low & ~rx;
                            bidx    <= bidx + 1'b1;
                        end
                    end
                    S_PARITY: begin
                        tcnt <= tnext;
                        if (at_last) begin
                            par_err <= rx ^ want_parity(shreg, par_even, par_stick);
                            all_low <= all_low & ~rx;
                        end
                    end
                    S_STOP: begin
                        tcnt <= tnext;
                        if (at_last) begin
                            if (rx) begin
                                push  <= 1'b1;
                                entry <= '{brk: 1'b0, par: par_err, frm: 1'b0, data: shreg};
                            end else if (!all_low) begin
                                push  <= 1'b1;
                                entry <= '{brk: 1'b0, par: par_err, frm: 1'b1, data: shreg};
                            end
                        end
                    end
                    S_BRKCHK: begin
                        tcnt <= tnext;
                        if (at_last) begin
                            push <= 1'b1;
                            if (rx)
                                entry <= '{brk: 1'b0, par: par_err, frm: 1'b1, data: shreg};
                            else
                                entry <= '{brk: 1'b1, par: 1'b0, frm: 1'b0, data: '0};
                        end
                    end
                    default: tcnt <= '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/arx_fifo.sv
module arx_fifo
    import arx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  rx_entry_t din,
    input  logic      pop,
    output rx_entry_t head,
    output logic      empty,
    output logic      full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] PMAX = AW'(DEPTH - 1);
    localparam logic [AW:0]   CMAX = (AW+1)'(DEPTH);

    rx_entry_t     mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CMAX);
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= (wr_ptr == PMAX) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop)
                rd_ptr <= (rd_ptr == PMAX) ? '0 : rd_ptr + 1'b1;
            cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end
endmodule

// File: rtl/arx_flags.sv
module arx_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic push,
    input  logic pop,
    input  logic empty,
    input  logic full,
    input  logic h_brk,
    input  logic h_par,
    input  logic h_frm,
    output logic stat_brk,
    output logic stat_par,
    output logic stat_frm,
    output logic stat_ovr
);
    logic mask, head_chg;

    assign head_chg = (pop & ~empty) | (push & empty);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask     <= 1'b0;
            stat_ovr <= 1'b0;
        end else begin
            if (clr)
                mask <= 1'b1;
            else if (head_chg)
                mask <= 1'b0;
            if (push && full)
                stat_ovr <= 1'b1;
            else if (clr)
                stat_ovr <= 1'b0;
        end
    end

    assign stat_brk = ~empty & ~mask & h_brk;
    assign stat_par = ~empty & ~mask & h_par;
    assign stat_frm = ~empty & ~mask & h_frm;
endmodule

// File: rtl/async_rx_core.sv
module async_rx_core
    import arx_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int OSR   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              rx_in,
    input  logic              par_en,
    input  logic              par_even,
    input  logic              par_stick,
    input  logic              rd_pop,
    input  logic              clr_wr,
    output logic              head_valid,
    output logic [DATA_W-1:0] head_data,
    output logic              stat_brk,
    output logic              stat_par,
    output logic              stat_frm,
    output logic              stat_ovr
);
    logic      rx_s;
    logic      fr_push;
    rx_entry_t fr_entry;
    rx_state_t fr_state;
    rx_entry_t ff_head;
    logic      ff_empty, ff_full;

    arx_sync #(.STAGES(2)) i_sync (
        .clk(clk), .rst_n(rst_n), .d(rx_in), .q(rx_s)
    );

    arx_frame #(.OSR(OSR)) i_frame (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .rx(rx_s),
        .par_en(par_en), .par_even(par_even), .par_stick(par_stick),
        .push(fr_push), .entry(fr_entry), .state_o(fr_state)
    );

    arx_fifo #(.DEPTH(DEPTH)) i_fifo (
        .clk(clk), .rst_n(rst_n), .push(fr_push), .din(fr_entry),
        .pop(rd_pop), .head(ff_head), .empty(ff_empty), .full(ff_full)
    );

    arx_flags i_flags (
        .clk(clk), .rst_n(rst_n), .clr(clr_wr), .push(fr_push), .pop(rd_pop),
        .empty(ff_empty), .full(ff_full),
        .h_brk(ff_head.brk), .h_par(ff_head.par), .h_frm(ff_head.frm),
        .stat_brk(stat_brk), .stat_par(stat_par), .stat_frm(stat_frm), .stat_ovr(stat_ovr)
    );

    assign head_valid = ~ff_empty;
    assign head_data  = ff_head.data;
endmodule

// File: rtl/arx_chk.sv
module arx_chk
    import arx_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      push,
    input rx_entry_t entry,
    input logic      full,
    input logic      pop,
    input logic      clr,
    input logic      rx_s,
    input rx_state_t state,
    input logic      stat_brk,
    input logic      stat_par,
    input logic      stat_frm,
    input logic      stat_ovr
);
    // R10
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push && full |=> stat_ovr);

    // R10
    ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_ovr && !clr |=> stat_ovr);

    // R11
    clr_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !stat_brk && !stat_par && !stat_frm);

    // R11
    clr_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !(push && full) |=> !stat_ovr);

    // R6
    brk_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push && entry.brk |-> entry.data == '0 && !entry.par && !entry.frm);

    // R7
    brk_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_BRKWAIT && !rx_s |=> state == S_BRKWAIT);

    // R8
    full_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full && !pop |=> full);
endmodule

bind async_rx_core arx_chk i_chk (
    .clk(clk), .rst_n(rst_n), .push(fr_push), .entry(fr_entry), .full(ff_full),
    .pop(rd_pop), .clr(clr_wr), .rx_s(rx_s), .state(fr_state),
    .stat_brk(stat_brk), .stat_par(stat_par), .stat_frm(stat_frm), .stat_ovr(stat_ovr)
);

// File: tb/test_async_rx_core.sv
`timescale 1ns/1ps
module test_async_rx_core;
    localparam int DEPTH  = 4;
    localparam int TDIV   = 4;
    localparam int BITCLK = 16 * TDIV;

    typedef struct {
        logic [7:0] data;
        logic       brk;
        logic       par;
        logic       frm;
    } ent_t;

    logic clk = 0, rst_n = 0, tick16 = 0, rx_in = 1;
    logic par_en = 0, par_even = 0, par_stick = 0, rd_pop = 0, clr_wr = 0;
    logic head_valid, stat_brk, stat_par, stat_frm, stat_ovr;
    logic [7:0] head_data;

    int    checks = 0, fails = 0, tdiv_cnt = 0;
    bit    settled = 0, done = 0;
    string cur_req = "R12";
    ent_t  exp_q[$];
    bit    m_mask = 0, m_ovr = 0;

    always #10 clk = ~clk;

    always @(negedge clk) begin
        tdiv_cnt = (tdiv_cnt + 1) % TDIV;
        tick16 = (tdiv_cnt == 0);
    end

    async_rx_core #(.DEPTH(DEPTH)) i_async_rx_core (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_in(rx_in),
        .par_en(par_en), .par_even(par_even), .par_stick(par_stick),
        .rd_pop(rd_pop), .clr_wr(clr_wr), .head_valid(head_valid), .head_data(head_data),
        .stat_brk(stat_brk), .stat_par(stat_par), .stat_frm(stat_frm), .stat_ovr(stat_ovr)
    );

    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
        end
    endtask

    function automatic ent_t mk(logic [7:0] d, logic b, logic p, logic f);
        ent_t e;
        e.data = d; e.brk = b; e.par = p; e.frm = f;
        return e;
    endfunction

    function automatic logic good_pbit(logic [7:0] d);
        int ones = 0;
        for (int i = 0; i < 8; i++) ones += d[i];
        if (par_stick) return par_even ? 1'b0 : 1'b1;
        if (par_even) return (ones % 2 == 1);
        return (ones % 2 == 0);
    endfunction

    // reference model
    task automatic m_push(ent_t e);
        if (exp_q.size() == DEPTH) m_ovr = 1;
        else begin
            if (exp_q.size() == 0) m_mask = 0;
            exp_q.push_back(e);
        end
    endtask

    task automatic compare_all();
        bit v;
        v = (exp_q.size() > 0);
        chk("head_valid", head_valid, v);
        if (v) begin
            chk("head_data", head_data, exp_q[0].data);
            chk("stat_brk", stat_brk, exp_q[0].brk & ~m_mask);
            chk("stat_par", stat_par, exp_q[0].par & ~m_mask);
            chk("stat_frm", stat_frm, exp_q[0].frm & ~m_mask);
        end else begin
            chk("stat_brk", stat_brk, 0);
            chk("stat_par", stat_par, 0);
            chk("stat_frm", stat_frm, 0);
        end
        chk("stat_ovr", stat_ovr, m_ovr);
    endtask

    always @(negedge clk) if (settled && rst_n && !done) compare_all();

    task automatic drive_bit(logic v);
        rx_in = v;
        repeat (BITCLK) @(negedge clk);
    endtask

    task automatic send_frame(logic [7:0] d, logic pbit, logic stopv, ent_t e);
        settled = 0;
        drive_bit(0);
        for (int i = 0; i < 8; i++) drive_bit(d[i]);
        if (par_en) drive_bit(pbit);
        drive_bit(stopv);
        rx_in = 1;
        repeat (3 * BITCLK) @(negedge clk);
        m_push(e);
        settled = 1;
        repeat (8) @(negedge clk);
    endtask

    task automatic send_ok(logic [7:0] d);
        send_frame(d, good_pbit(d), 1'b1, mk(d, 0, 0, 0));
    endtask

    task automatic do_pop();
        @(negedge clk); rd_pop = 1;
        @(posedge clk); #1 rd_pop = 0;
        if (exp_q.size() > 0) begin
            void'(exp_q.pop_front());
            m_mask = 0;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic do_clr();
        @(negedge clk); clr_wr = 1;
        @(posedge clk); #1 clr_wr = 0;
        m_mask = 1; m_ovr = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (4) @(negedge clk);
        // R12 reset state
        cur_req = "R12";
        chk("reset head_valid", head_valid, 0);
        chk("reset stat_ovr", stat_ovr, 0);
        settled = 1;
        repeat (10) @(negedge clk);

        // R2 no parity, LSB first
        cur_req = "R2";
        send_ok(8'hA5);
        send_ok(8'h3C);
        cur_req = "R8";
        chk("order head", head_data, 8'hA5);
        do_pop(); do_pop();

        // R3 even and odd parity
        cur_req = "R3";
        par_en = 1; par_even = 1;
        send_ok(8'h5A);
        send_frame(8'h01, ~good_pbit(8'h01), 1'b1, mk(8'h01, 0, 1, 0));
        do_pop();
        chk("even mismatch par", stat_par, 1);
        do_pop();
        par_even = 0;
        send_ok(8'h07);
        send_frame(8'h80, ~good_pbit(8'h80), 1'b1, mk(8'h80, 0, 1, 0));
        do_pop(); do_pop();

        // R4 stick parity
        cur_req = "R4";
        par_stick = 1; par_even = 1;
        send_frame(8'hFF, 1'b0, 1'b1, mk(8'hFF, 0, 0, 0));
        send_frame(8'h12, 1'b1, 1'b1, mk(8'h12, 0, 1, 0));
        do_pop(); do_pop();
        par_even = 0;
        send_frame(8'h00, 1'b1, 1'b1, mk(8'h00, 0, 0, 0));
        send_frame(8'h33, 1'b0, 1'b1, mk(8'h33, 0, 1, 0));
        do_pop(); do_pop();
        par_stick = 0; par_en = 0;

        // R5 framing errors
        cur_req = "R5";
        send_frame(8'h55, 1'b0, 1'b0, mk(8'h55, 0, 0, 1));
        chk("frm flag", stat_frm, 1);
        send_frame(8'h00, 1'b0, 1'b0, mk(8'h00, 0, 0, 1));
        do_pop(); do_pop();

        // R1 false start
        cur_req = "R1";
        settled = 0;
        rx_in = 0;
        repeat (4 * TDIV) @(negedge clk);
        rx_in = 1;
        repeat (3 * BITCLK) @(negedge clk);
        settled = 1;
        repeat (8) @(negedge clk);
        chk("no char after glitch", head_valid, 0);

        // R6 break, R7 lockout
        cur_req = "R6";
        settled = 0;
        rx_in = 0;
        repeat (14 * BITCLK) @(negedge clk);
        m_push(mk(8'h00, 1, 0, 0));
        settled = 1;
        repeat (8) @(negedge clk);
        chk("break flag", stat_brk, 1);
        cur_req = "R7";
        repeat (16 * BITCLK) @(negedge clk);
        rx_in = 1;
        repeat (2 * BITCLK) @(negedge clk);
        send_ok(8'h42);
        chk("after break", head_data, 8'h00);
        do_pop();
        chk("post-break char", head_data, 8'h42);

        // R9, R11 head flags and clear
        cur_req = "R9";
        send_frame(8'h99, 1'b0, 1'b0, mk(8'h99, 0, 0, 1));
        par_en = 1; par_even = 1;
        send_frame(8'h81, ~good_pbit(8'h81), 1'b1, mk(8'h81, 0, 1, 0));
        par_en = 0;
        do_pop();
        chk("head frm", stat_frm, 1);
        cur_req = "R11";
        do_clr();
        chk("frm cleared", stat_frm, 0);
        do_pop();
        chk("next head par", stat_par, 1);
        do_clr();
        do_pop();

        // R10 overrun
        cur_req = "R10";
        for (int k = 0; k < DEPTH + 1; k++) send_ok(8'(8'h10 + k));
        chk("ovr set", stat_ovr, 1);
        do_pop();
        chk("ovr sticky", stat_ovr, 1);
        cur_req = "R11";
        do_clr();
        chk("ovr cleared", stat_ovr, 0);
        cur_req = "R10";
        for (int k = 1; k < DEPTH; k++) do_pop();

        // R8 pop on empty
        cur_req = "R8";
        do_pop();
        chk("empty pop", head_valid, 0);

        settled = 0;
        finish_run();
    end
endmodule